// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Framing

This block turns bytes written into a small transmit queue into asynchronous serial characters on a single output line. Each character is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit and a stop period, which is a high line. The timing of each bit comes from a 16x bit-rate enable that a baud divisor outside the block produces. One cycle-wide pulse of that enable is one sixteenth of a bit.

The queue has two capacities. In buffered mode it holds up to sixteen bytes. In single mode it holds one byte, which acts as a plain holding register in front of the shift stage. A break input forces the line low while it is asserted. An optional clear-to-send gate holds back the start of each new character until the partner signals readiness. Three flags report the state of the block. One shows that the queue is empty. One shows that the whole transmitter is drained. One shows that there is room for a write, which suits a DMA request.

Top module: `uart_tx_frame`

## Requirements
- R1: With `fifo_mode_i`=1 the queue accepts up to 16 bytes, and with `fifo_mode_i`=0 it accepts 1 byte. `dma_rdy_o` is high exactly when the stored count is below that capacity. A write while `dma_rdy_o` is low is dropped, and the stored bytes keep their order.
- R2: When the shift stage is idle and the queue is non-empty (and the CTS gate is open), the head byte is taken on the next clock edge and `txd_o` goes low for the start bit from that edge on. Every start, data and parity bit lasts exactly 16 enable pulses counted after that edge.
- R3: `char_len_i` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data is sent LSB first, and the byte bits above the selected length are never sent.
- R4: With `par_en_i`=1 a parity bit follows the data. When `par_odd_i`=0 the number of ones in the data bits plus the parity bit is even, and when `par_odd_i`=1 it is odd. With `par_en_i`=0 no parity bit is sent.
- R5: The stop period is high and lasts 16 pulses when `stop_long_i`=0. When `stop_long_i`=1 it lasts 24 pulses with 5-bit characters and 32 pulses with 6 to 8 bit characters.
- R6: The framing inputs are captured when a character starts. Changing them mid-character affects only later characters.
- R7: While `brk_i`=1, `txd_o` is low in the same cycle. Break does not change the queue contents or the progress of the character being sent.
- R8: With `auto_cts_i`=1 and `cts_i`=0 no new start bit is issued. A character already in progress when `cts_i` falls is finished in full.
- R9: `tx_empty_o` is high only when the queue is empty and the last stop period has ended. It rises on the edge that ends the final stop pulse count.
- R10: After reset `txd_o` is high, both empty flags are high and `dma_rdy_o` is high. An idle line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | 16x bit-rate enable pulse |
| fifo_mode_i | input | 1 | 1: 16-byte queue, 0: single holding byte |
| wr_en_i | input | 1 | Write strobe for one byte |
| wr_data_i | input | 8 | Byte to queue |
| char_len_i | input | 2 | Data length code (0..3 = 5..8 bits) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| stop_long_i | input | 1 | Long stop period (1.5 or 2 bits) |
| brk_i | input | 1 | Force line low |
| auto_cts_i | input | 1 | Enable clear-to-send start gating |
| cts_i | input | 1 | Clear to send, active high |
| txd_o | output | 1 | Serial output line |
| fifo_empty_o | output | 1 | Queue holds no byte |
| tx_empty_o | output | 1 | Queue empty and shift stage idle |
| dma_rdy_o | output | 1 | Room for at least one write |

## Verification
Each write is counted on the edge where it is strobed, so `fifo_empty_o` and `dma_rdy_o` change on that same edge. The start bit appears on the edge after the queue becomes non-empty. Each later bit boundary falls on the edge that registers the 16th (or 24th or 32nd) enable pulse, and `txd_o` follows `brk_i` within the same cycle. The bench keeps a behavioural model that is built from queues of bit values and durations. The model is updated on every rising edge from the inputs applied at the previous falling edge. All four outputs are compared with it 2 ns after each edge, and targeted checks at chosen moments confirm the full-queue, gating, break and drained states.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;        // 0..3 -> 5..8 data bits
        logic       par_en;
        logic       par_odd;
        logic       stop_long;
    } frame_cfg_t;

endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_mode_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         pop_i,
    output logic [W-1:0] rd_data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t    r_d, r_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic [CW-1:0] limit;
    logic          push;

    function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        limit = fifo_mode_i ? CW'(DEPTH) : CW'(1);
        full_o  = (r_q.cnt >= limit);
        empty_o = (r_q.cnt == '0);
        push    = wr_en_i && !full_o;
        r_d = r_q;
        if (push) begin
            r_d.wptr = ptr_next(r_q.wptr);
        end
        if (pop_i) begin
            r_d.rptr = ptr_next(r_q.rptr);
        end
        if (push && !pop_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end else if (!push && pop_i) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[r_q.wptr] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[r_q.rptr];

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(DEPTH));

    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && full_o && !pop_i) |=> $stable(r_q.cnt));

    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int unsigned TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  frame_cfg_t        cfg_i,
    input  logic              auto_cts_i,
    input  logic              cts_i,
    input  logic              have_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pop_o,
    output logic              busy_o,
    output logic              line_o
);
    localparam int unsigned TW = $clog2(2 * TICKS);

    typedef struct packed {
        tx_state_e         state;
        logic [TW-1:0]     tcnt;
        logic [2:0]        idx;
        logic [DATA_W-1:0] shreg;
        logic              par;
        frame_cfg_t        cfg;
    } shift_regs_t;

    shift_regs_t       s_d, s_q;
    logic [DATA_W-1:0] masked;
    logic [TW-1:0]     last;
    logic [TW-1:0]     stop_last;
    logic [2:0]        idx_end;

    always_comb begin
        masked    = data_i & (8'hFF >> (2'd3 - cfg_i.len));
        idx_end   = {1'b0, s_q.cfg.len} + 3'd4;
        if (!s_q.cfg.stop_long) begin
            stop_last = TW'(TICKS - 1);
        end else if (s_q.cfg.len == 2'd0) begin
            stop_last = TW'(TICKS + TICKS / 2 - 1);
        end else begin
            stop_last = TW'(2 * TICKS - 1);
        end
        last  = (s_q.state == ST_STOP) ? stop_last : TW'(TICKS - 1);
        s_d   = s_q;
        pop_o = 1'b0;
        if (s_q.state == ST_IDLE) begin
            if (have_i && (!auto_cts_i || cts_i)) begin
                pop_o     = 1'b1;
                s_d.state = ST_START;
                s_d.tcnt  = '0;
                s_d.idx   = '0;
                s_d.cfg   = cfg_i;
                s_d.shreg = masked;
                s_d.par   = (^masked) ^ cfg_i.par_odd;
            end
        end else if (tick_i) begin
            if (s_q.tcnt != last) begin
                s_d.tcnt = s_q.tcnt + 1'b1;
            end else begin
                s_d.tcnt = '0;
                case (s_q.state)
                    ST_START: s_d.state = ST_DATA;
                    ST_DATA: begin
                        if (s_q.idx == idx_end) begin
                            s_d.state = s_q.cfg.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            s_d.idx   = s_q.idx + 1'b1;
                            s_d.shreg = s_q.shreg >> 1;
                        end
                    end
                    ST_PAR:  s_d.state = ST_STOP;
                    default: s_d.state = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.state)
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = s_q.shreg[0];
            ST_PAR:   line_o = s_q.par;
            default:  line_o = 1'b1;
        endcase
    end

    assign busy_o = (s_q.state != ST_IDLE);

    p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE && auto_cts_i && !cts_i) |=> (s_q.state == ST_IDLE));

    p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && s_q.state != ST_IDLE) |=> $stable(s_q.tcnt));

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_IDLE && $past(s_q.state) != ST_IDLE) |-> $stable(s_q.cfg));

    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_DATA) |-> (s_q.idx <= idx_end));

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH    = 16,
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16_i,
    input  logic       fifo_mode_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic [1:0] char_len_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       stop_long_i,
    input  logic       brk_i,
    input  logic       auto_cts_i,
    input  logic       cts_i,
    output logic       txd_o,
    output logic       fifo_empty_o,
    output logic       tx_empty_o,
    output logic       dma_rdy_o
);
    logic              pop;
    logic              empty;
    logic              full;
    logic              busy;
    logic              line;
    logic [DATA_W-1:0] head;
    frame_cfg_t        cfg;

    assign cfg = '{len: char_len_i, par_en: par_en_i, par_odd: par_odd_i,
                   stop_long: stop_long_i};

    tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (DATA_W)
    ) i_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode_i (fifo_mode_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .pop_i       (pop),
        .rd_data_o   (head),
        .empty_o     (empty),
        .full_o      (full)
    );

    tx_shifter #(
        .TICKS (TICKS_PER_BIT)
    ) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick16_i),
        .cfg_i      (cfg),
        .auto_cts_i (auto_cts_i),
        .cts_i      (cts_i),
        .have_i     (!empty),
        .data_i     (head),
        .pop_o      (pop),
        .busy_o     (busy),
        .line_o     (line)
    );

    assign txd_o        = line & ~brk_i;
    assign fifo_empty_o = empty;
    assign tx_empty_o   = empty & ~busy;
    assign dma_rdy_o    = ~full;

endmodule

// File: tb/test_uart_tx_frame.sv
`timescale 1ns/1ps
module test_uart_tx_frame;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       fifo_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop_long = 1'b0;
    logic       brk = 1'b0;
    logic       auto_cts = 1'b0;
    logic       cts = 1'b1;
    logic       txd, fifo_empty, tx_empty, dma_rdy;

    int nchk = 0;
    int nerr = 0;
    int tdiv = 2;
    int tc = 0;
    bit cmp_en = 0;
    string cur_req = "R10";

    uart_tx_frame i_uart_tx_frame (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .fifo_mode_i(fifo_mode),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .char_len_i(char_len),
        .par_en_i(par_en), .par_odd_i(par_odd), .stop_long_i(stop_long),
        .brk_i(brk), .auto_cts_i(auto_cts), .cts_i(cts), .txd_o(txd),
        .fifo_empty_o(fifo_empty), .tx_empty_o(tx_empty), .dma_rdy_o(dma_rdy)
    );

    always #5 clk = ~clk;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] q[$];
    bit         bval[$];
    int         bdur[$];
    int         rcnt = 0;
    bit         rbusy = 0;
    int         sz, lim;
    bit         acc;
    logic [7:0] wb;

    task automatic build(logic [7:0] d);
        int nb;
        bit p;
        nb = int'(char_len) + 5;
        p = par_odd;
        bval.push_back(1'b0); bdur.push_back(16);
        for (int i = 0; i < nb; i++) begin
            bval.push_back(d[i]); bdur.push_back(16);
            p = p ^ d[i];
        end
        if (par_en) begin
            bval.push_back(p); bdur.push_back(16);
        end
        bval.push_back(1'b1);
        bdur.push_back(!stop_long ? 16 : (char_len == 2'd0 ? 24 : 32));
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); bval.delete(); bdur.delete();
            rbusy = 0; rcnt = 0;
        end else begin
            sz  = q.size();
            lim = fifo_mode ? 16 : 1;
            acc = wr_en && (sz < lim);
            wb  = wr_data;
            if (!rbusy) begin
                if (sz > 0 && (!auto_cts || cts)) begin
                    build(q.pop_front());
                    rbusy = 1; rcnt = 0;
                end
            end else if (tick16) begin
                rcnt++;
                if (rcnt == bdur[0]) begin
                    void'(bval.pop_front());
                    void'(bdur.pop_front());
                    rcnt = 0;
                    if (bval.size() == 0) rbusy = 0;
                end
            end
            if (acc) q.push_back(wb);
        end
        #2;
        if (cmp_en) begin
            check(cur_req, "txd", 32'(txd), 32'(brk ? 1'b0 : (rbusy ? bval[0] : 1'b1)));
            check("R1", "fifo_empty", 32'(fifo_empty), 32'(q.size() == 0));
            check("R1", "dma_rdy", 32'(dma_rdy), 32'(q.size() < (fifo_mode ? 16 : 1)));
            check("R9", "tx_empty", 32'(tx_empty), 32'(q.size() == 0 && !rbusy));
        end
    end

    // tick generator
    initial begin
        forever begin
            @(negedge clk);
            if (tc >= tdiv - 1) begin
                tick16 = 1'b1; tc = 0;
            end else begin
                tick16 = 1'b0; tc++;
            end
        end
    end

    task automatic write_byte(logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (tx_empty && !rbusy && q.size() == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #1000000;
        nerr++; nchk++;
        $display("FAIL watchdog expired (R2): actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R10", "reset txd", 32'(txd), 32'd1);
        check("R10", "reset fifo_empty", 32'(fifo_empty), 32'd1);
        check("R10", "reset tx_empty", 32'(tx_empty), 32'd1);
        check("R10", "reset dma_rdy", 32'(dma_rdy), 32'd1);
        rst_n = 1'b1;
        cmp_en = 1;
        repeat (5) @(negedge clk);

        // R2: 8 data bits, no parity, one stop
        cur_req = "R2";
        write_byte(8'hA5);
        write_byte(8'h3C);
        wait_idle();
        check("R10", "idle line high", 32'(txd), 32'd1);

        // R4 odd parity, R5 5-bit long stop = 24 pulses
        cur_req = "R4"; tdiv = 1;
        char_len = 2'd0; par_en = 1'b1; par_odd = 1'b1; stop_long = 1'b1;
        write_byte(8'hF3);
        write_byte(8'h0E);
        wait_idle();

        // R5: 7 bits, even parity, long stop = 32 pulses
        cur_req = "R5"; tdiv = 3;
        char_len = 2'd2; par_odd = 1'b0;
        write_byte(8'h55);
        write_byte(8'hD6);
        wait_idle();

        // R3: 6 bits, upper byte bits not sent
        cur_req = "R3"; tdiv = 2;
        char_len = 2'd1; par_en = 1'b0; stop_long = 1'b0;
        write_byte(8'hC7);
        wait_idle();

        // R6: framing changed mid-character
        cur_req = "R6";
        char_len = 2'd3;
        write_byte(8'h96);
        write_byte(8'h69);
        repeat (60) @(negedge clk);
        char_len = 2'd0; par_en = 1'b1; par_odd = 1'b0; stop_long = 1'b1;
        wait_idle();

        // R1 full queue, R8 CTS gating
        cur_req = "R8"; tdiv = 1;
        char_len = 2'd3; par_en = 1'b0; stop_long = 1'b0;
        auto_cts = 1'b1; cts = 1'b0;
        for (int i = 0; i < 18; i++) write_byte(8'(8'h10 + i));
        check("R1", "dma_rdy when 16 held", 32'(dma_rdy), 32'd0);
        check("R1", "fifo_empty when full", 32'(fifo_empty), 32'd0);
        repeat (50) @(negedge clk);
        check("R8", "no start while cts low", 32'(txd), 32'd1);
        cts = 1'b1;
        repeat (20) @(negedge clk);
        cts = 1'b0;
        check("R8", "char in progress", 32'(tx_empty), 32'd0);
        repeat (400) @(negedge clk);
        check("R8", "held after completion", 32'(txd), 32'd1);
        check("R8", "queue still holds bytes", 32'(fifo_empty), 32'd0);
        cts = 1'b1;
        wait_idle();
        check("R9", "drained", 32'(tx_empty), 32'd1);

        // R1 single holding byte
        cur_req = "R1";
        fifo_mode = 1'b0; cts = 1'b0;
        write_byte(8'hE1);
        write_byte(8'h1E);
        check("R1", "single mode full", 32'(dma_rdy), 32'd0);
        cts = 1'b1;
        wait_idle();
        auto_cts = 1'b0; fifo_mode = 1'b1;

        // R7 break mid-character and while idle
        cur_req = "R7"; tdiv = 2;
        write_byte(8'hFF);
        repeat (40) @(negedge clk);
        brk = 1'b1;
        repeat (30) @(negedge clk);
        check("R7", "break forces low", 32'(txd), 32'd0);
        brk = 1'b0;
        wait_idle();
        brk = 1'b1;
        repeat (10) @(negedge clk);
        check("R7", "break while idle", 32'(txd), 32'd0);
        check("R7", "break leaves tx_empty", 32'(tx_empty), 32'd1);
        brk = 1'b0;
        repeat (5) @(negedge clk);

        cmp_en = 0;
        finish_run();
    end
endmodule